// File: doc/BRIEF.md
# Tributary Counter Snapshot Register Bank

This block is a byte-wide register interface with a 9-bit address. It holds two 16-bit receive performance counters for each of up to 21 tributaries. Each counter counts one-cycle event strobes that arrive from outside the block. Software never reads a running counter directly. A write to either byte address of a counter is a request to freeze that counter. The count is moved into a shadow, and the counter restarts for the next interval. After a fixed settle window the shadow is copied into a readable buffer, and software can then fetch the two bytes in either order.

Address bits [8:4] select the tributary and bits [3:0] select a register inside it. Tributary numbers 1 to 21 map onto 010h–15Fh. Everything else is the global region, which holds no storage here and reads as zero.

Each counter channel runs a two-state controller. **SNAP_IDLE** leaves the buffer untouched and accepts a freeze request (transition *accept*: IDLE→SETTLE). **SNAP_SETTLE** counts the settle window down. Further requests are dropped while it counts. When the countdown reaches zero, the controller copies the shadow into the buffer (transition *commit*: SETTLE→IDLE).

Top module: `trib_snap_bank`

## Requirements
- R1: An address whose bits [8:4] are 0 or 22–31 (000h–00Fh, 160h–1FFh) reads 00h, and a write to it changes no counter or buffer.
- R2: In tributary N (1–21), counter A's buffer appears at offset 9 (bits 15:8) and offset 8 (bits 7:0), and counter B's buffer at offset 7 (bits 15:8) and offset 6 (bits 7:0).
- R3: Each rising clock edge with a channel's event strobe high adds one to that counter, and a counter at FFFFh stays at FFFFh.
- R4: A write with wr_en to either byte address of an idle counter freezes its current value, whatever wdata holds.
- R5: The frozen value becomes readable exactly three rising edges after the edge that took the write, and earlier reads return the previous buffer contents.
- R6: A frozen counter restarts at zero, and an event on the freezing edge counts as 1 in the new interval.
- R7: A freeze request that reaches a counter still in its settle window is ignored, and that counter is not cleared.
- R8: Tributary offsets other than 6–9 read 00h, and writes to them have no effect.
- R9: rdata is 00h whenever rd_en is low, and reading has no side effect, so the two bytes of a buffer may be read in either order.
- R10: After reset all counters and buffers are zero and every channel is in SNAP_IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 9 | Register byte address |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data (ignored by counter registers) |
| rd_en | input | 1 | Read enable; gates rdata |
| rdata | output | 8 | Combinational read data |
| evt_a | input | 21 | Event strobes for counter A, bit i is tributary i+1 |
| evt_b | input | 21 | Event strobes for counter B, bit i is tributary i+1 |

## Verification
An event strobe and a freeze request can hit the same counter on the same edge. The freeze must capture the old total while the strobe opens the new interval at one. The bench drives every strobe high on each freeze write, and it also repeats a freeze inside the settle window with strobes active. It then freezes again later and checks that the earlier strobes were neither lost nor counted twice, using totals it keeps per channel. After each of these cases it reads all 512 addresses and checks each byte against those totals.

// File: rtl/tsb_pkg.sv
package tsb_pkg;
    typedef enum logic {
        SNAP_IDLE   = 1'b0,
        SNAP_SETTLE = 1'b1
    } snap_state_e;
endpackage

// File: rtl/tsb_addr_dec.sv
module tsb_addr_dec #(
    parameter int TRIB_W   = 5,
    parameter int OFF_W    = 4,
    parameter int NUM_TRIB = 21
) (
    input  logic [TRIB_W+OFF_W-1:0] addr,
    output logic                    trib_hit,
    output logic [TRIB_W-1:0]       trib_idx,
    output logic                    cnt_hit,
    output logic                    cnt_sel,
    output logic                    hi_byte
);
    localparam int ADDR_W = TRIB_W + OFF_W;
    localparam logic [OFF_W-1:0] OFF_B_LO = OFF_W'(6);
    localparam logic [OFF_W-1:0] OFF_B_HI = OFF_W'(7);
    localparam logic [OFF_W-1:0] OFF_A_LO = OFF_W'(8);
    localparam logic [OFF_W-1:0] OFF_A_HI = OFF_W'(9);

    logic [TRIB_W-1:0] trib_num;
    logic [OFF_W-1:0]  offset;

    assign trib_num = addr[ADDR_W-1 -: TRIB_W];
    assign offset   = addr[OFF_W-1:0];
    assign trib_hit = (trib_num != '0) && (trib_num <= TRIB_W'(NUM_TRIB));
    assign trib_idx = trib_num - TRIB_W'(1);

    always_comb begin
        cnt_hit = 1'b1;
        cnt_sel = 1'b0;
        hi_byte = 1'b0;
        unique case (offset)
            OFF_A_LO: begin cnt_sel = 1'b0; hi_byte = 1'b0; end
            OFF_A_HI: begin cnt_sel = 1'b0; hi_byte = 1'b1; end
            OFF_B_LO: begin cnt_sel = 1'b1; hi_byte = 1'b0; end
            OFF_B_HI: begin cnt_sel = 1'b1; hi_byte = 1'b1; end
            default:  cnt_hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tsb_snap_chan.sv
module tsb_snap_chan
    import tsb_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int SETTLE_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt,
    input  logic             trig,
    output logic [CNT_W-1:0] snap_buf
);
    localparam int               TMR_W    = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [TMR_W-1:0] TMR_LOAD = TMR_W'(SETTLE_CYC - 1);

    snap_state_e      state_q, state_d;
    logic [TMR_W-1:0] timer_q;
    logic [CNT_W-1:0] cnt_q, shadow_q;
    logic             take, commit;

    assign take   = (state_q == SNAP_IDLE) && trig;
    assign commit = (state_q == SNAP_SETTLE) && (timer_q == '0);

    // next-state: accept (IDLE->SETTLE), commit (SETTLE->IDLE)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SNAP_IDLE:   if (trig)            state_d = SNAP_SETTLE;
            SNAP_SETTLE: if (timer_q == '0)   state_d = SNAP_IDLE;
            default:                          state_d = SNAP_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SNAP_IDLE;
        else        state_q <= state_d;
    end

    // datapath driven by the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q    <= '0;
            shadow_q <= '0;
            timer_q  <= '0;
            snap_buf <= '0;
        end else begin
            if (take)
                cnt_q <= {{(CNT_W-1){1'b0}}, evt};
            else if (evt && (cnt_q != CNT_MAX))
                cnt_q <= cnt_q + CNT_W'(1);

            if (take) begin
                shadow_q <= cnt_q;
                timer_q  <= TMR_LOAD;
            end else if ((state_q == SNAP_SETTLE) && (timer_q != '0)) begin
                timer_q <= timer_q - TMR_W'(1);
            end

            if (commit)
                snap_buf <= shadow_q;
        end
    end

    // R3
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !take) |=> (cnt_q == CNT_MAX));

    // R6
    cap_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (cnt_q <= CNT_W'(1)));

    // R5
    buf_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_IDLE) |=> $stable(snap_buf));

    // R7
    settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SNAP_SETTLE && timer_q != '0) |=>
            (state_q == SNAP_SETTLE && $stable(shadow_q)));
endmodule

// File: rtl/trib_snap_bank.sv
module trib_snap_bank #(
    parameter int NUM_TRIB   = 21,
    parameter int SETTLE_CYC = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [8:0]          addr,
    input  logic                wr_en,
    input  logic [7:0]          wdata,
    input  logic                rd_en,
    output logic [7:0]          rdata,
    input  logic [NUM_TRIB-1:0] evt_a,
    input  logic [NUM_TRIB-1:0] evt_b
);
    localparam int TRIB_W  = 5;
    localparam int OFF_W   = 4;
    localparam int DATA_W  = 8;
    localparam int CNT_W   = 2 * DATA_W;
    localparam int NUM_CNT = 2;

    logic              trib_hit, cnt_hit, cnt_sel, hi_byte;
    logic [TRIB_W-1:0] trib_idx;
    logic [CNT_W-1:0]  snap_buf [NUM_TRIB][NUM_CNT];
    logic [NUM_TRIB*NUM_CNT-1:0] trig_vec;
    logic [CNT_W-1:0]  sel_word;
    logic              unused_wdata;

    assign unused_wdata = ^wdata;

    tsb_addr_dec #(
        .TRIB_W  (TRIB_W),
        .OFF_W   (OFF_W),
        .NUM_TRIB(NUM_TRIB)
    ) i_dec (
        .addr    (addr),
        .trib_hit(trib_hit),
        .trib_idx(trib_idx),
        .cnt_hit (cnt_hit),
        .cnt_sel (cnt_sel),
        .hi_byte (hi_byte)
    );

    for (genvar t = 0; t < NUM_TRIB; t++) begin : g_trib
        for (genvar c = 0; c < NUM_CNT; c++) begin : g_cnt
            assign trig_vec[t*NUM_CNT + c] = wr_en && trib_hit && cnt_hit &&
                (trib_idx == TRIB_W'(t)) && (cnt_sel == 1'(c));

            tsb_snap_chan #(
                .CNT_W     (CNT_W),
                .SETTLE_CYC(SETTLE_CYC)
            ) i_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .evt     ((c == 0) ? evt_a[t] : evt_b[t]),
                .trig    (trig_vec[t*NUM_CNT + c]),
                .snap_buf(snap_buf[t][c])
            );
        end
    end

    always_comb begin
        sel_word = '0;
        rdata    = '0;
        if (rd_en && trib_hit && cnt_hit) begin
            sel_word = snap_buf[trib_idx][cnt_sel];
            rdata    = hi_byte ? sel_word[CNT_W-1:DATA_W] : sel_word[DATA_W-1:0];
        end
    end

    // R9
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));

    // R1
    glob_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && (addr[8:4] == '0 || addr[8:4] > 5'(NUM_TRIB))) |-> (rdata == '0));

    // R4
    one_trig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(trig_vec));
endmodule

// File: tb/test_trib_snap_bank.sv
`timescale 1ns/1ps
module test_trib_snap_bank;
    localparam int NT = 21;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [8:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wdata = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rdata;
    logic [NT-1:0] evt_a = '0;
    logic [NT-1:0] evt_b = '0;

    int n_chk = 0;
    int n_fail = 0;

    int m_cnt  [NT][2];
    int m_pend [NT][2];
    int m_left [NT][2];
    int m_buf  [NT][2];

    always #2.5 clk = ~clk;

    trib_snap_bank i_trib_snap_bank (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .evt_a(evt_a), .evt_b(evt_b)
    );

    // expected byte per R1, R2, R8
    function automatic logic [7:0] exp_rd(input logic [8:0] a);
        int t = int'(a[8:4]);
        int o = int'(a[3:0]);
        if (t < 1 || t > NT) return 8'h00;
        case (o)
            8: return 8'(m_buf[t-1][0]);
            9: return 8'(m_buf[t-1][0] >> 8);
            6: return 8'(m_buf[t-1][1]);
            7: return 8'(m_buf[t-1][1] >> 8);
            default: return 8'h00;
        endcase
    endfunction

    task automatic tick(input logic [NT-1:0] ea, input logic [NT-1:0] eb,
                        input logic w, input logic [8:0] a, input logic [7:0] d);
        int t, o;
        @(negedge clk);
        evt_a = ea; evt_b = eb; wr_en = w; addr = a; wdata = d; rd_en = 1'b0;
        @(posedge clk);
        #1;
        t = int'(a[8:4]);
        o = int'(a[3:0]);
        for (int ti = 0; ti < NT; ti++) begin
            for (int ci = 0; ci < 2; ci++) begin
                logic ev, hit, busy;
                ev   = (ci == 0) ? ea[ti] : eb[ti];
                hit  = w && (t == ti + 1) &&
                       ((ci == 0 && (o == 8 || o == 9)) || (ci == 1 && (o == 6 || o == 7)));
                busy = (m_left[ti][ci] != 0);
                if (hit && !busy) begin
                    m_pend[ti][ci] = m_cnt[ti][ci];
                    m_left[ti][ci] = 3;
                    m_cnt[ti][ci]  = ev ? 1 : 0;
                end else begin
                    if (busy) begin
                        m_left[ti][ci]--;
                        if (m_left[ti][ci] == 0) m_buf[ti][ci] = m_pend[ti][ci];
                    end
                    if (ev && m_cnt[ti][ci] < 65535) m_cnt[ti][ci]++;
                end
            end
        end
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick('0, '0, 1'b0, 9'h000, 8'h00);
    endtask

    task automatic read_chk(input logic [8:0] a, input string req);
        logic [7:0] e;
        wr_en = 1'b0; rd_en = 1'b1; addr = a;
        #1;
        e = exp_rd(a);
        n_chk++;
        if (rdata !== e) begin
            n_fail++;
            $display("FAIL %s addr=%03h rdata=%02h expected=%02h", req, a, rdata, e);
        end
        rd_en = 1'b0;
    endtask

    task automatic sweep(input string req);
        for (int a = 0; a < 512; a++) read_chk(9'(a), req);
    endtask

    task automatic pattern(input int n, input int seed);
        for (int c = 0; c < n; c++) begin
            logic [NT-1:0] ea, eb;
            for (int i = 0; i < NT; i++) begin
                ea[i] = ((c + seed) % (i + 1)) == 0;
                eb[i] = ((c + i + seed) % 3) == 0;
            end
            tick(ea, eb, 1'b0, 9'h000, 8'h00);
        end
    endtask

    initial begin
        #(190000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int t = 0; t < NT; t++)
            for (int c = 0; c < 2; c++) begin
                m_cnt[t][c] = 0; m_pend[t][c] = 0; m_left[t][c] = 0; m_buf[t][c] = 0;
            end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10: all buffers zero after reset
        sweep("R10");

        pattern(60, 0);
        // R3 R6 R4 R5 R2: freeze each counter with all strobes high on the freeze edge
        for (int t = 1; t <= NT; t++) begin
            tick('1, '1, 1'b1, {5'(t), 4'h9}, 8'hA5);
            read_chk({5'(t), 4'h8}, "R5");
            idle(2);
            read_chk({5'(t), 4'h9}, "R5");
            idle(1);
            read_chk({5'(t), 4'h9}, "R2");
            read_chk({5'(t), 4'h8}, "R2");
            tick('1, '1, 1'b1, {5'(t), 4'h6}, 8'h3C);
            idle(3);
            read_chk({5'(t), 4'h6}, "R9");
            read_chk({5'(t), 4'h7}, "R9");
        end
        sweep("R6");

        // R7: second request inside the settle window with strobes active
        pattern(17, 4);
        tick('0, '0, 1'b1, 9'h058, 8'h00);
        tick('1, '1, 1'b1, 9'h059, 8'hFF);
        tick('1, '1, 1'b1, 9'h057, 8'hFF);
        idle(3);
        tick('0, '0, 1'b1, 9'h059, 8'h00);
        tick('0, '0, 1'b1, 9'h056, 8'h00);
        idle(3);
        sweep("R7");

        // R1 R8: writes to global and unused offsets change nothing
        pattern(9, 2);
        for (int o = 0; o < 16; o++)
            if (o < 6 || o > 9) tick('1, '1, 1'b1, {5'd3, 4'(o)}, 8'hFF);
        tick('1, '1, 1'b1, 9'h000, 8'hFF);
        tick('1, '1, 1'b1, 9'h00F, 8'hFF);
        tick('1, '1, 1'b1, 9'h160, 8'hFF);
        tick('1, '1, 1'b1, 9'h1FF, 8'hFF);
        idle(4);
        sweep("R8");
        for (int t = 1; t <= NT; t++) begin
            tick('0, '0, 1'b1, {5'(t), 4'h8}, 8'h00);
            tick('0, '0, 1'b1, {5'(t), 4'h7}, 8'h00);
        end
        idle(4);
        sweep("R1");

        // R9: rd_en low gives zero on a loaded address
        wr_en = 1'b0; rd_en = 1'b0; addr = 9'h158; #1;
        n_chk++;
        if (rdata !== 8'h00) begin
            n_fail++;
            $display("FAIL R9 rdata=%02h expected=00", rdata);
        end

        // R3: saturation at FFFFh
        for (int c = 0; c < 65540; c++) tick('1, '1, 1'b0, 9'h000, 8'h00);
        for (int t = 1; t <= NT; t++) begin
            tick('0, '0, 1'b1, {5'(t), 4'h9}, 8'h00);
            tick('0, '0, 1'b1, {5'(t), 4'h6}, 8'h00);
        end
        idle(4);
        sweep("R3");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule